// File: doc/BRIEF.md
# ALU Status Flag Unit

This block is the arithmetic core of a small processor datapath together with the status byte that arithmetic maintains. Each cycle in which the valid strobe is high, it takes an opcode, operands and a shift count. It then registers a result and updates the flags. The supported operations are add, add-with-carry, subtract, subtract-with-borrow, logical left shift, logical right shift and an unsigned double-width-by-single-width divide.

The carry-chained forms keep the zero flag meaningful over a whole multi-word value. The negative flag reports the true sign of a result even after a signed overflow. A sticky overflow bit remembers that an overflow happened at some point. Two control bits, transaction enable and interrupt enable, ride along in the same byte and change only when the byte is restored.

A save port copies the byte out and clears it, and a restore port loads a whole byte. Together they model how the status is pushed to and popped from a stack around a subroutine or an interrupt. The datapath width and the shift-count width are parameters.

Top module: `alu_flag_unit`

## Requirements
- R1: The status byte `flags`, from bit 7 down to bit 0, is zero (Z), negative (N), overflow (V), sticky overflow (VT), carry (C), transaction enable (PSE), interrupt enable (I) and sticky bit (ST). Synchronous reset clears `flags`, `result` and `saved_flags` to 0.
- R2: The opcodes are 0 = add, 1 = add with carry in C, 2 = subtract, 3 = subtract with borrow (borrow in = not C). All operate on the low W bits of `opnd_a` and on `opnd_b`. One cycle after a strobed operation, `result` holds the W-bit result zero-extended. C holds the carry out, or for subtracts 1 when no borrow occurred. V is set on signed overflow.
- R3: Add, subtract and both shifts set Z when the W-bit result is zero and clear it otherwise. Add with carry and subtract with borrow set Z only if the result is zero and Z was already 1.
- R4: For opcodes 0 to 3, N is the sign of the exact signed result, which equals the result MSB XOR V.
- R5: Opcode 4 shifts the low W bits of `opnd_a` left by `shift_cnt`, filling with zeros. N is the result MSB, even for a count of 0. V is set if the MSB takes a different value after any single step of the shift. For a nonzero count, C is the last bit shifted out; a count of 0 leaves C unchanged.
- R6: Opcode 5 shifts logically right by `shift_cnt`, with N the result MSB and V cleared. For a nonzero count, C is the last bit shifted out and ST is the OR of all earlier bits shifted out. A count of 0 leaves C and ST unchanged.
- R7: Opcode 6 divides the 2W-bit unsigned `opnd_a` by the W-bit `opnd_b`. `result` gets the remainder in bits 2W-1..W and the quotient's low W bits in bits W-1..0. V is set when the quotient needs more than W bits. Z, N, C and ST are unchanged.
- R8: A divide with `opnd_b` = 0 sets V and leaves `result` unchanged.
- R9: VT becomes 1 whenever a strobed operation sets V. VT is cleared only by restore, save or `sticky_clr`, and `sticky_clr` wins over a simultaneous set.
- R10: `save_req` copies `flags` into `saved_flags` and clears `flags` to 0 on the same edge. `restore_req` takes priority over `save_req`, and either one suppresses a simultaneous operation, so `result` holds its value.
- R11: `restore_req` loads `flags` with `restore_val` in full.
- R12: With the strobe low, or with opcode 7, `flags` and `result` do not change. PSE and I change only through restore or save.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Operation strobe |
| op_code | input | 3 | Operation select |
| opnd_a | input | 2*W | First operand; dividend for divide, low W bits otherwise |
| opnd_b | input | W | Second operand; divisor for divide |
| shift_cnt | input | CW | Shift distance |
| sticky_clr | input | 1 | Clears the sticky overflow bit |
| save_req | input | 1 | Copy status out and clear it |
| restore_req | input | 1 | Load status byte from restore_val |
| restore_val | input | 8 | Status byte to restore |
| result | output | 2*W | Registered result |
| flags | output | 8 | Registered status byte |
| saved_flags | output | 8 | Status byte captured by the last save |

## Verification
The bench builds the unit with W = 4 and CW = 3, so shift counts run from 0 to 7 and reach past the full operand width. At that size, every operand pair of all four add and subtract forms can be swept, with the carry and zero chain carried from one operation to the next. The sweeps also cover every operand and count of both shifts and every 8-bit dividend against every 4-bit divisor, including zero. Short directed sequences then exercise the priority of save, restore and sticky clear, and show that idle cycles and the unused opcode leave the state alone.

// File: rtl/alu_flag_pkg.sv
package alu_flag_pkg;

  typedef enum logic [2:0] {
    OP_ADD  = 3'd0,
    OP_ADDC = 3'd1,
    OP_SUB  = 3'd2,
    OP_SUBB = 3'd3,
    OP_SHL  = 3'd4,
    OP_SHR  = 3'd5,
    OP_DIV  = 3'd6,
    OP_NONE = 3'd7
  } alu_op_e;

  // bit positions inside the status byte
  localparam int FB_Z   = 7;
  localparam int FB_N   = 6;
  localparam int FB_V   = 5;
  localparam int FB_VT  = 4;
  localparam int FB_C   = 3;
  localparam int FB_PSE = 2;
  localparam int FB_I   = 1;
  localparam int FB_ST  = 0;

endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
  parameter int W = 16
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sub,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         cout,
  output logic         ovf,
  output logic         neg,
  output logic         zero
);

  logic [W-1:0] b_eff;

  always_comb begin
    b_eff       = sub ? ~b : b;
    {cout, sum} = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, cin};
    ovf         = (a[W-1] ^ sum[W-1]) & (b_eff[W-1] ^ sum[W-1]);
    neg         = sum[W-1] ^ ovf;
    zero        = (sum == '0);
  end

endmodule

// File: rtl/alu_shifter.sv
module alu_shifter #(
  parameter int W  = 16,
  parameter int CW = 5
) (
  input  logic [W-1:0]  a,
  input  logic [CW-1:0] cnt,
  input  logic          right,
  output logic [W-1:0]  res,
  output logic          last_out,
  output logic          sticky,
  output logic          ovf
);

  localparam int MAXC = (1 << CW) - 1;
  localparam int XW   = W + MAXC;

  logic [XW-1:0] wide_l;
  logic [XW-1:0] wide_r;
  logic [XW-1:0] ext_hi;
  logic          msb_moved;

  always_comb begin
    wide_l    = {{MAXC{1'b0}}, a} << cnt;
    ext_hi    = {a, {MAXC{1'b0}}};
    wide_r    = ext_hi >> cnt;
    msb_moved = 1'b0;
    for (int k = 1; k <= MAXC; k++) begin
      if (k <= int'(cnt))
        msb_moved = msb_moved | (ext_hi[XW-1-k] ^ a[W-1]);
    end
    if (right) begin
      res      = wide_r[XW-1 -: W];
      last_out = wide_r[MAXC-1];
      sticky   = |wide_r[MAXC-2:0];
      ovf      = 1'b0;
    end else begin
      res      = wide_l[W-1:0];
      last_out = wide_l[W];
      sticky   = 1'b0;
      ovf      = msb_moved;
    end
  end

endmodule

// File: rtl/alu_divider.sv
module alu_divider #(
  parameter int W = 16
) (
  input  logic [2*W-1:0] dvd,
  input  logic [W-1:0]   dvs,
  output logic [2*W-1:0] quot,
  output logic [W-1:0]   rem,
  output logic           q_ovf
);

  logic [W-1:0] part [0:2*W];

  assign part[0] = '0;

  for (genvar j = 0; j < 2*W; j++) begin : g_stage
    logic [W:0] trial;
    logic [W:0] diff;
    logic       ge;
    assign trial            = {part[j], dvd[2*W-1-j]};
    assign ge               = (trial >= {1'b0, dvs});
    assign diff             = trial - {1'b0, dvs};
    assign quot[2*W-1-j]    = ge;
    assign part[j+1]        = ge ? diff[W-1:0] : trial[W-1:0];
  end

  assign rem   = part[2*W];
  assign q_ovf = |quot[2*W-1:W];

endmodule

// File: rtl/alu_flag_unit.sv
module alu_flag_unit
  import alu_flag_pkg::*;
#(
  parameter int W  = 16,
  parameter int CW = 5
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           op_valid,
  input  logic [2:0]     op_code,
  input  logic [2*W-1:0] opnd_a,
  input  logic [W-1:0]   opnd_b,
  input  logic [CW-1:0]  shift_cnt,
  input  logic           sticky_clr,
  input  logic           save_req,
  input  logic           restore_req,
  input  logic [7:0]     restore_val,
  output logic [2*W-1:0] result,
  output logic [7:0]     flags,
  output logic [7:0]     saved_flags
);

  alu_op_e op;
  assign op = alu_op_e'(op_code);

  logic [7:0]     flags_q, flags_d;
  logic [2*W-1:0] res_q, res_d;
  logic [7:0]     saved_q;

  // add / subtract
  logic         as_sub, as_cin, as_c, as_v, as_n, as_z;
  logic [W-1:0] as_sum;
  assign as_sub = (op == OP_SUB) || (op == OP_SUBB);
  assign as_cin = (op == OP_ADD) ? 1'b0 :
                  (op == OP_SUB) ? 1'b1 : flags_q[FB_C];

  alu_addsub #(.W(W)) u_addsub (
    .a(opnd_a[W-1:0]), .b(opnd_b), .sub(as_sub), .cin(as_cin),
    .sum(as_sum), .cout(as_c), .ovf(as_v), .neg(as_n), .zero(as_z)
  );

  // shifts
  logic [W-1:0] sh_res;
  logic         sh_c, sh_st, sh_v;
  alu_shifter #(.W(W), .CW(CW)) u_shift (
    .a(opnd_a[W-1:0]), .cnt(shift_cnt), .right(op == OP_SHR),
    .res(sh_res), .last_out(sh_c), .sticky(sh_st), .ovf(sh_v)
  );

  // divide
  logic [2*W-1:0] dv_quot;
  logic [W-1:0]   dv_rem;
  logic           dv_ovf;
  alu_divider #(.W(W)) u_div (
    .dvd(opnd_a), .dvs(opnd_b), .quot(dv_quot), .rem(dv_rem), .q_ovf(dv_ovf)
  );

  logic v_raised;

  always_comb begin
    flags_d  = flags_q;
    res_d    = res_q;
    v_raised = 1'b0;
    if (op_valid) begin
      unique case (op)
        OP_ADD, OP_ADDC, OP_SUB, OP_SUBB: begin
          res_d          = {{W{1'b0}}, as_sum};
          flags_d[FB_C]  = as_c;
          flags_d[FB_V]  = as_v;
          flags_d[FB_N]  = as_n;
          flags_d[FB_Z]  = (op == OP_ADDC || op == OP_SUBB) ?
                           (flags_q[FB_Z] & as_z) : as_z;
          v_raised       = as_v;
        end
        OP_SHL, OP_SHR: begin
          res_d          = {{W{1'b0}}, sh_res};
          flags_d[FB_N]  = sh_res[W-1];
          flags_d[FB_Z]  = (sh_res == '0);
          flags_d[FB_V]  = sh_v;
          v_raised       = sh_v;
          if (shift_cnt != '0) begin
            flags_d[FB_C] = sh_c;
            if (op == OP_SHR) flags_d[FB_ST] = sh_st;
          end
        end
        OP_DIV: begin
          if (opnd_b == '0) begin
            flags_d[FB_V] = 1'b1;
            v_raised      = 1'b1;
          end else begin
            res_d         = {dv_rem, dv_quot[W-1:0]};
            flags_d[FB_V] = dv_ovf;
            v_raised      = dv_ovf;
          end
        end
        default: ;
      endcase
    end
    flags_d[FB_VT] = (flags_q[FB_VT] | v_raised) & ~sticky_clr;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flags_q <= '0;
      res_q   <= '0;
      saved_q <= '0;
    end else if (restore_req) begin
      flags_q <= restore_val;
    end else if (save_req) begin
      saved_q <= flags_q;
      flags_q <= '0;
    end else begin
      flags_q <= flags_d;
      res_q   <= res_d;
    end
  end

  assign result      = res_q;
  assign flags       = flags_q;
  assign saved_flags = saved_q;

  // R11 restore loads the byte
  a_r11_restore_loads: assert property (@(posedge clk) disable iff (rst)
    restore_req |=> flags == $past(restore_val));

  // R10 save copies out and clears
  a_r10_save_clears: assert property (@(posedge clk) disable iff (rst)
    (save_req && !restore_req) |=> (flags == 8'h00) && (saved_flags == $past(flags)));

  // R10 save or restore suppresses an operation
  a_r10_result_held: assert property (@(posedge clk) disable iff (rst)
    (save_req || restore_req) |=> $stable(result));

  // R9 sticky overflow never drops by itself
  a_r9_vt_sticky: assert property (@(posedge clk) disable iff (rst)
    (flags[FB_VT] && !sticky_clr && !save_req && !restore_req) |=> flags[FB_VT]);

  // R12 control bits only move through restore or save
  a_r12_ctrl_stable: assert property (@(posedge clk) disable iff (rst)
    (!save_req && !restore_req) |=> $stable(flags[FB_PSE:FB_I]));

  // R12 idle cycles leave state alone
  a_r12_idle_stable: assert property (@(posedge clk) disable iff (rst)
    (!op_valid && !save_req && !restore_req && !sticky_clr) |=> $stable(flags) && $stable(result));

  // R3 carry-chained forms never raise Z
  a_r3_chain_no_set: assert property (@(posedge clk) disable iff (rst)
    (op_valid && (op_code == 3'd1 || op_code == 3'd3) && !flags[FB_Z] &&
     !save_req && !restore_req) |=> !flags[FB_Z]);

  // R8 divide by zero keeps result and raises V
  a_r8_divz_hold: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_code == 3'd6 && opnd_b == '0 && !save_req && !restore_req)
      |=> $stable(result) && flags[FB_V]);

endmodule

// File: tb/tb_alu_flag_unit.sv
module tb_alu_flag_unit;

  localparam int W  = 4;
  localparam int CW = 3;
  localparam int MASK = (1 << W) - 1;

  logic           clk = 1'b0;
  logic           rst;
  logic           op_valid;
  logic [2:0]     op_code;
  logic [2*W-1:0] opnd_a;
  logic [W-1:0]   opnd_b;
  logic [CW-1:0]  shift_cnt;
  logic           sticky_clr;
  logic           save_req;
  logic           restore_req;
  logic [7:0]     restore_val;
  logic [2*W-1:0] result;
  logic [7:0]     flags;
  logic [7:0]     saved_flags;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  int m_flags = 0;
  int m_res = 0;

  always #4 clk = ~clk;

  alu_flag_unit #(.W(W), .CW(CW)) dut (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code),
    .opnd_a(opnd_a), .opnd_b(opnd_b), .shift_cnt(shift_cnt),
    .sticky_clr(sticky_clr), .save_req(save_req), .restore_req(restore_req),
    .restore_val(restore_val), .result(result), .flags(flags),
    .saved_flags(saved_flags)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int setb(input int f, input int pos, input int v);
    return (v != 0) ? (f | (1 << pos)) : (f & ~(1 << pos));
  endfunction

  function automatic int sgn(input int x);
    return (x >= (1 << (W-1))) ? x - (1 << W) : x;
  endfunction

  task automatic idle_inputs();
    op_valid = 0; op_code = 0; opnd_a = 0; opnd_b = 0; shift_cnt = 0;
    sticky_clr = 0; save_req = 0; restore_req = 0; restore_val = 0;
  endtask

  task automatic run_op(input int op, input int a, input int b, input int cnt,
                        input bit clr, input string tag);
    int ef = m_flags;
    int er = m_res;
    int c = (m_flags >> 3) & 1;
    int z = (m_flags >> 7) & 1;
    int vnew = -1;
    if (op <= 3) begin
      int r, s, ov, neg;
      if (op <= 1) begin
        int ci = (op == 1) ? c : 0;
        r  = a + b + ci;
        s  = sgn(a) + sgn(b) + ci;
        ef = setb(ef, 3, (r >> W) & 1);
      end else begin
        int bo = (op == 3) ? (1 - c) : 0;
        r  = a - b - bo;
        s  = sgn(a) - sgn(b) - bo;
        ef = setb(ef, 3, (r >= 0) ? 1 : 0);
      end
      ov  = (s > (1 << (W-1)) - 1 || s < -(1 << (W-1))) ? 1 : 0;
      neg = (s < 0) ? 1 : 0;
      r   = r & MASK;
      er  = r;
      ef  = setb(ef, 5, ov);
      ef  = setb(ef, 6, neg);
      if (op == 1 || op == 3) ef = setb(ef, 7, (z == 1 && r == 0) ? 1 : 0);
      else                   ef = setb(ef, 7, (r == 0) ? 1 : 0);
      vnew = ov;
    end else if (op == 4) begin
      int x = a;
      int ov = 0;
      for (int k = 0; k < cnt; k++) begin
        int nx = (x << 1) & MASK;
        if (((nx >> (W-1)) & 1) != ((x >> (W-1)) & 1)) ov = 1;
        x = nx;
      end
      er = x;
      ef = setb(ef, 6, (x >> (W-1)) & 1);
      ef = setb(ef, 7, (x == 0) ? 1 : 0);
      ef = setb(ef, 5, ov);
      if (cnt != 0) ef = setb(ef, 3, (cnt <= W) ? ((a >> (W - cnt)) & 1) : 0);
      vnew = ov;
    end else if (op == 5) begin
      int x = a >> cnt;
      er = x;
      ef = setb(ef, 6, (x >> (W-1)) & 1);
      ef = setb(ef, 7, (x == 0) ? 1 : 0);
      ef = setb(ef, 5, 0);
      if (cnt != 0) begin
        ef = setb(ef, 3, (a >> (cnt - 1)) & 1);
        ef = setb(ef, 0, ((a & ((1 << (cnt - 1)) - 1)) != 0) ? 1 : 0);
      end
      vnew = 0;
    end else if (op == 6) begin
      if (b == 0) begin
        ef = setb(ef, 5, 1);
        vnew = 1;
      end else begin
        int q = a / b;
        int rm = a % b;
        int ov = (q > MASK) ? 1 : 0;
        er = ((rm & MASK) << W) | (q & MASK);
        ef = setb(ef, 5, ov);
        vnew = ov;
      end
    end
    if (vnew == 1) ef = setb(ef, 4, 1);
    if (clr) ef = setb(ef, 4, 0);
    @(negedge clk);
    op_valid = 1; op_code = op[2:0]; opnd_a = a[2*W-1:0];
    opnd_b = b[W-1:0]; shift_cnt = cnt[CW-1:0]; sticky_clr = clr;
    @(posedge clk);
    #2;
    op_valid = 0; sticky_clr = 0;
    m_flags = ef;
    m_res = er;
    check({tag, " flags"}, int'(flags), ef);
    check({tag, " result"}, int'(result), er);
  endtask

  task automatic ctrl(input bit sv, input bit rs, input int val, input bit withop);
    @(negedge clk);
    save_req = sv; restore_req = rs; restore_val = val[7:0];
    op_valid = withop; op_code = 3'd0; opnd_a = 1; opnd_b = 1;
    @(posedge clk);
    #2;
    save_req = 0; restore_req = 0; op_valid = 0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R12 watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int saved_before;
    idle_inputs();
    rst = 1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    #1;
    check("R1 reset flags", int'(flags), 0);
    check("R1 reset result", int'(result), 0);
    check("R1 reset saved", int'(saved_flags), 0);

    // R11 restore control bits for the sweeps that follow
    ctrl(0, 1, 8'h06, 0);
    m_flags = 8'h06;
    check("R11 restore", int'(flags), 8'h06);

    // R2 R3 R4 add and subtract sweeps with chained carry and zero
    for (int op = 0; op < 4; op++)
      for (int a = 0; a <= MASK; a++)
        for (int b = 0; b <= MASK; b++)
          run_op(op, a, b, 0, 0, "R2 R3 R4");

    // R3 directed zero chain
    run_op(0, 0, 0, 0, 0, "R3 add zero");
    run_op(1, 0, 0, 0, 0, "R3 addc keeps Z");
    run_op(0, 1, 1, 0, 0, "R3 add nonzero");
    run_op(1, 0, 0, 0, 0, "R3 addc no set");
    check("R3 Z after chain", (int'(flags) >> 7) & 1, 0);

    // R5 R6 shift sweeps
    for (int a = 0; a <= MASK; a++)
      for (int cnt = 0; cnt < (1 << CW); cnt++) begin
        run_op(4, a, 0, cnt, 0, "R5 shl");
        run_op(5, a, 0, cnt, 0, "R6 shr");
      end

    // R7 R8 divide sweep
    for (int b = 0; b <= MASK; b++)
      for (int a = 0; a < (1 << (2*W)); a++)
        run_op(6, a, b, 0, 0, (b == 0) ? "R8 divz" : "R7 div");

    // R9 sticky overflow
    run_op(0, 7, 1, 0, 0, "R9 set");
    check("R9 vt set", (int'(flags) >> 4) & 1, 1);
    run_op(0, 1, 1, 0, 0, "R9 held");
    check("R9 vt held", (int'(flags) >> 4) & 1, 1);
    run_op(7, 1, 1, 0, 1, "R9 clear");
    check("R9 vt cleared", (int'(flags) >> 4) & 1, 0);
    run_op(0, 7, 1, 0, 1, "R9 clear wins");
    check("R9 v with clear", (int'(flags) >> 4) & 3, 2);

    // R12 opcode 7 and idle
    run_op(7, 5, 9, 3, 0, "R12 op7");
    @(negedge clk);
    opnd_a = 8'h3C; opnd_b = 4'h9; op_code = 3'd0;
    @(posedge clk);
    #2;
    check("R12 idle flags", int'(flags), m_flags);
    check("R12 idle result", int'(result), m_res);

    // R10 save then priorities
    ctrl(0, 1, 8'hA5, 0);
    check("R11 restore full", int'(flags), 8'hA5);
    saved_before = int'(result);
    ctrl(1, 0, 0, 1);
    check("R10 save cleared", int'(flags), 0);
    check("R10 save copy", int'(saved_flags), 8'hA5);
    check("R10 op suppressed", int'(result), saved_before);
    ctrl(1, 1, 8'h5A, 0);
    check("R10 restore over save", int'(flags), 8'h5A);
    check("R10 saved kept", int'(saved_flags), 8'hA5);
    ctrl(0, 1, 8'h00, 0);
    check("R11 restore zero", int'(flags), 0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule